// File: doc/BRIEF.md
# Watchdog Timer Core

This block is a watchdog down-counter that software controls through two 32-bit registers: a control/status word and a timeout word. Software loads a timeout in ticks, sets the run bit and then keeps the counter alive by writing a one-shot reload trigger at intervals. If the counter runs down to zero while it is running, the block latches a sticky fired flag. It also raises a single-clock request to the surrounding logic, either a system reset or a shutdown, depending on the action bit.

Counting is paced by a tick strobe that is produced elsewhere. A hardware disable input holds the counter frozen, and the control word reports that input as a read-only bit. Register access is a simple single-cycle write port with a combinational read path.

Top module: `wdt_core`

## Requirements
- R1: After synchronous reset both registers read 0, the internal counter is 0, and neither request output is high.
- R2: A write to offset 0x4 stores bits 15:0 as the timeout, and reads of 0x4 return the timeout with bits 31:16 as zero. Accesses to any offset other than 0x0 and 0x4 read 0 and change nothing.
- R3: In the control word at offset 0x0, bit 0 (run) and bit 2 (action) are read/write. Bits 6:4 and bits 31:8 always read 0, and bit 7 (reload) always reads 0.
- R4: Writing 1 to control bit 7 copies the timeout into the counter, and a timeout of 0 loads 1.
- R5: The counter decrements by one on each tick only while run is 1 and the disable input is 0. Clearing run holds the count, so setting run again continues from the held value.
- R6: A tick that takes the counter from 1 to 0 sets the fired flag (bit 1) and pulses exactly one request for one clock in the following cycle. That request is the reset request when bit 2 is 0 and the shutdown request when bit 2 is 1. A counter already at 0 never fires again until it is reloaded.
- R7: The fired flag is write-1-to-clear, and writing 0 to bit 1 leaves it unchanged.
- R8: Control bit 3 reads the disable input. While that input is high no tick decrements the counter and no request is raised.
- R9: A single control write that sets reload, run and the fired-clear bit applies all three together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_disable | input | 1 | Hardware disable for the watchdog |
| tick | input | 1 | One-clock count strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-clock reset request on expiry |
| shut_req | output | 1 | One-clock shutdown request on expiry |

## Verification
A counter state that is off by one shows up directly at the outputs: the request pulse arrives one tick early or one tick late, measured from the last reload. The bench therefore counts the exact ticks to expiry after every reload. A wrong fired or action state shows on the very next read of the control word, or as a pulse on the wrong request line in the clock after the expiring tick. A counter that fails to stay at zero after expiry shows as extra pulses, and the bench counts every pulse and also checks that each one lasts a single clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h4;

    localparam int B_RUN    = 0;
    localparam int B_FIRED  = 1;
    localparam int B_ACTION = 2;
    localparam int B_DIS    = 3;
    localparam int B_RELOAD = 7;

    typedef enum logic {
        ACT_RESET    = 1'b0,
        ACT_SHUTDOWN = 1'b1
    } wdt_action_e;

    typedef struct packed {
        logic        run;
        logic        fired;
        wdt_action_e action;
    } wdt_ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_word(wdt_ctrl_t c, logic dis);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[B_RUN]    = c.run;
        w[B_FIRED]  = c.fired;
        w[B_ACTION] = c.action;
        w[B_DIS]    = dis;
        return w;
    endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_disable,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              expire,
    output logic [DATA_W-1:0] bus_rdata,
    output wdt_ctrl_t         ctrl,
    output logic [CW-1:0]     timeout,
    output logic              reload
);
    localparam int PAD_W = DATA_W - CW;

    logic wr_ctrl, wr_count;
    logic unused_wdata;

    assign wr_ctrl      = bus_wr && (bus_addr == AW'(OFS_CTRL));
    assign wr_count     = bus_wr && (bus_addr == AW'(OFS_COUNT));
    assign reload       = wr_ctrl && bus_wdata[B_RELOAD];
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '{run: 1'b0, fired: 1'b0, action: ACT_RESET};
            timeout <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.run    <= bus_wdata[B_RUN];
                ctrl.action <= wdt_action_e'(bus_wdata[B_ACTION]);
            end
            if (expire)
                ctrl.fired <= 1'b1;
            else if (wr_ctrl && bus_wdata[B_FIRED])
                ctrl.fired <= 1'b0;
            if (wr_count)
                timeout <= bus_wdata[CW-1:0];
        end
    end

    always_comb begin
        case (bus_addr)
            AW'(OFS_CTRL):  bus_rdata = ctrl_word(ctrl, hw_disable);
            AW'(OFS_COUNT): bus_rdata = {{PAD_W{1'b0}}, timeout};
            default:        bus_rdata = '0;
        endcase
    end

    assert_fired_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.fired && !(wr_ctrl && bus_wdata[B_FIRED])) |=> ctrl.fired);
    assert_expire_sets_R6: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl.fired);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          hw_disable,
    input  logic          tick,
    input  logic          reload,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    logic          step;
    logic [CW-1:0] start_val;

    assign step      = tick && run && !hw_disable && (cnt != '0) && !reload;
    assign expire    = step && (cnt == CW'(1));
    assign start_val = (load_val == '0) ? CW'(1) : load_val;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (reload)
            cnt <= start_val;
        else if (step)
            cnt <= cnt - CW'(1);
    end

    assert_reload_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        reload |=> (cnt != '0));
    assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (rst)
        (!run && !reload) |=> $stable(cnt));
    assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        (hw_disable && !reload) |=> $stable(cnt));
endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        expire,
    input  wdt_action_e action,
    output logic        rst_req,
    output logic        shut_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req  <= 1'b0;
            shut_req <= 1'b0;
        end else begin
            rst_req  <= expire && (action == ACT_RESET);
            shut_req <= expire && (action == ACT_SHUTDOWN);
        end
    end

    assert_one_request_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_req, shut_req}));
    assert_rst_single_R6: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    assert_shut_single_R6: assert property (@(posedge clk) disable iff (rst)
        shut_req |=> !shut_req);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_disable,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              shut_req
);
    wdt_ctrl_t     ctrl;
    logic [CW-1:0] timeout;
    logic [CW-1:0] cnt;
    logic          reload;
    logic          expire;

    wdt_regs #(.CW(CW), .AW(AW)) regs_i (
        .clk(clk), .rst(rst), .hw_disable(hw_disable),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .expire(expire), .bus_rdata(bus_rdata),
        .ctrl(ctrl), .timeout(timeout), .reload(reload)
    );

    wdt_counter #(.CW(CW)) cnt_i (
        .clk(clk), .rst(rst), .run(ctrl.run), .hw_disable(hw_disable),
        .tick(tick), .reload(reload), .load_val(timeout),
        .cnt(cnt), .expire(expire)
    );

    wdt_action act_i (
        .clk(clk), .rst(rst), .expire(expire), .action(ctrl.action),
        .rst_req(rst_req), .shut_req(shut_req)
    );

    assert_request_implies_fired_R6: assert property (@(posedge clk) disable iff (rst)
        (rst_req || shut_req) |-> ctrl.fired);
    assert_silent_when_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        (hw_disable && $past(hw_disable)) |-> !(rst_req || shut_req));
    assert_zero_no_refire_R6: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '0) && !reload) |=> !(rst_req || shut_req));
endmodule

// File: tb/wdt_core_tb.sv
module wdt_core_tb_top;
    localparam int OP_WR = 0, OP_RD = 1, OP_TK = 2, OP_PC = 3;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 4'h0, 32'h0,          32'h0},          // R1 ctrl reset
        '{2'd1, 4'h4, 32'h0,          32'h0},          // R1 count reset
        '{2'd0, 4'h4, 32'hABCD0005,   32'h0},
        '{2'd1, 4'h4, 32'h0,          32'h5},          // R2 upper dropped
        '{2'd0, 4'h0, 32'h000000F1,   32'h0},
        '{2'd1, 4'h0, 32'h0,          32'h1},          // R3 reserved/reload read 0
        '{2'd2, 4'h0, 32'd3,          32'h0},
        '{2'd0, 4'h0, 32'h00000081,   32'h0},
        '{2'd2, 4'h0, 32'd4,          32'h0},
        '{2'd1, 4'h0, 32'h0,          32'h1},          // R4 reload restarted count
        '{2'd3, 4'h0, 32'h0,          32'h0},          // R4 no pulse yet
        '{2'd2, 4'h0, 32'd1,          32'h0},
        '{2'd1, 4'h0, 32'h0,          32'h3},          // R6 fired
        '{2'd3, 4'h0, 32'h0,          32'h00000001},   // R6 one reset pulse
        '{2'd0, 4'h0, 32'h00000003,   32'h0},
        '{2'd1, 4'h0, 32'h0,          32'h1},          // R7 cleared
        '{2'd2, 4'h0, 32'd3,          32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_disable = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, shut_req;

    int n_checks = 0;
    int n_fail = 0;
    int rst_pulses = 0;
    int shut_pulses = 0;
    int long_pulses = 0;
    logic prev_rq = 1'b0, prev_sq = 1'b0;

    always #2 clk = ~clk;

    wdt_core dut_i (
        .clk(clk), .rst(rst), .hw_disable(hw_disable), .tick(tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req), .shut_req(shut_req)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rst_req) rst_pulses++;
            if (shut_req) shut_pulses++;
            if ((rst_req && prev_rq) || (shut_req && prev_sq)) long_pulses++;
        end
        prev_rq = rst_req;
        prev_sq = shut_req;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulses(string req, logic [31:0] exp);
        check(req, {16'(shut_pulses), 16'(rst_pulses)}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reqs low", {30'd0, shut_req, rst_req}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            case (int'(VECS[v].op))
                OP_WR: wr(VECS[v].addr, VECS[v].data);
                OP_RD: rd($sformatf("R1-table vec %0d", v), VECS[v].addr, VECS[v].exp);
                OP_TK: ticks(int'(VECS[v].data));
                default: pulses($sformatf("R6 table vec %0d", v), VECS[v].exp);
            endcase
        end
        pulses("R6 no refire at zero", 32'h00000001);

        // R5 stop holds count, resume continues
        wr(4'h4, 32'd3);
        wr(4'h0, 32'h81);
        ticks(1);
        wr(4'h0, 32'h0);
        ticks(5);
        rd("R5 stopped ctrl", 4'h0, 32'h0);
        wr(4'h0, 32'h1);
        ticks(1);
        pulses("R5 held count not expired", 32'h00000001);
        ticks(1);
        pulses("R5 resumed count expired", 32'h00000002);

        // R7 write 0 keeps fired, write 1 clears
        rd("R7 fired set", 4'h0, 32'h3);
        wr(4'h0, 32'h1);
        rd("R7 write 0 keeps", 4'h0, 32'h3);
        wr(4'h0, 32'h3);
        rd("R7 w1c", 4'h0, 32'h1);

        // R4 zero timeout loads 1, R6 shutdown action
        wr(4'h4, 32'h0);
        wr(4'h0, 32'h85);
        rd("R3 action bit", 4'h0, 32'h5);
        ticks(1);
        pulses("R4 zero->one tick, R6 shutdown", 32'h00010002);
        rd("R6 fired shutdown", 4'h0, 32'h7);

        // R9 reload + run + clear in one write
        wr(4'h4, 32'd2);
        wr(4'h0, 32'h83);
        rd("R9 combined write", 4'h0, 32'h1);
        ticks(1);
        pulses("R9 one tick left", 32'h00010002);
        ticks(1);
        pulses("R9 expiry after two", 32'h00010003);

        // R8 disable
        hw_disable = 1'b1;
        wr(4'h0, 32'h83);
        rd("R8 disable bit", 4'h0, 32'h9);
        ticks(5);
        pulses("R8 no fire disabled", 32'h00010003);
        rd("R8 not fired", 4'h0, 32'h9);
        hw_disable = 1'b0;
        @(negedge clk);
        ticks(2);
        pulses("R8 resumes after enable", 32'h00010004);

        // R2 unmapped offset
        wr(4'h8, 32'hFFFFFFFF);
        rd("R2 unmapped read", 4'h8, 32'h0);
        rd("R2 count unchanged", 4'h4, 32'h2);
        rd("R2 ctrl unchanged", 4'h0, 32'h3);

        check("R6 pulse width", 32'(long_pulses), 32'h0);

        // R1 reset mid-run
        wr(4'h0, 32'h85);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd("R1 ctrl after reset", 4'h0, 32'h0);
        rd("R1 count after reset", 4'h4, 32'h0);
        ticks(3);
        check("R1 reqs after reset", {30'd0, shut_req, rst_req}, 32'h0);
        pulses("R1 no fire after reset", 32'h00010004);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule